// File: doc/BRIEF.md
# Answer-to-Reset Window Monitor

This block watches a smart card while it is being brought up and decides when the card reset line is released. Once the power sequencer raises `enable`, the card clock is running, and each card clock pulse arrives as a one-cycle `tick` strobe. The monitor counts these pulses and watches the card data line for a start bit, which is a falling edge on the line. It releases the card reset at a fixed pulse count and sorts the card's first answer into three outcomes: too early, on time, or missing.

There are two counting phases. In the cold phase, reset is held low. A start bit in the opening guard span is ignored. A start bit after the guard span but before reset is released raises both the EARLY and MUTE flags, holds reset low and leaves the decision to the host. In the warm phase, after reset rises, a start bit that comes too soon raises EARLY. A start bit in the proper span freezes the counter and raises `answered`. If no start bit arrives at all, MUTE is raised. After any of these outcomes the monitor idles until `enable` falls. The flags stay set until the host clears them.

The sequencer has six states. `ST_OFF` is idle with the counter cleared. `ST_COLD` is the reset-low count. `ST_WARM` is the reset-high count. `ST_DONE` means the card answered. `ST_SILENT` means MUTE was raised after reset went high. `ST_HALT` means the card answered before reset was released.

The transitions are:
- OFF to COLD on `enable`.
- COLD to WARM on the last cold tick.
- COLD to HALT on a start bit after the guard span.
- WARM to DONE on any start bit.
- WARM to SILENT on the last warm tick.
- Any state to OFF when `enable` falls.

Top module: `atr_window_monitor`

## Requirements
- R1: The data line is synchronized through two flip-flops. A start bit is a high-to-low transition of the synchronized level, and a rising transition is never taken as a start bit.
- R2: In ST_COLD, a start bit seen while fewer than IGNORE_TICKS ticks have been counted has no effect: no flag is set, reset stays low and counting continues.
- R3: In ST_COLD, a start bit seen with a count from IGNORE_TICKS to COLD_TICKS-1 sets both early_flag and mute_flag. The monitor then enters ST_HALT, card_rst stays low and further ticks have no effect.
- R4: If no start bit is accepted, card_rst goes high on the COLD_TICKS-th tick after enable and the counter restarts from zero.
- R5: In ST_WARM, a start bit with a count below EARLY_TICKS sets early_flag and raises answered.
- R6: In ST_WARM, a start bit with a count from EARLY_TICKS to MUTE_TICKS-1 raises answered with no flag. The counter then freezes, and later ticks and start bits change nothing.
- R7: If no start bit arrives in ST_WARM, the MUTE_TICKS-th tick sets mute_flag. card_rst stays high, answered stays low and later start bits are ignored.
- R8: early_flag and mute_flag stay set until a flag_clr pulse, which clears both.
- R9: While enable is low, card_rst and answered are low and the counter is cleared. The flags keep their values.
- R10: After rst_n, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Card clock running, from the sequencer |
| tick | input | 1 | One-cycle strobe per card clock pulse |
| io_in | input | 1 | Raw card data line level |
| flag_clr | input | 1 | Host pulse that clears early_flag and mute_flag |
| card_rst | output | 1 | Card reset line |
| early_flag | output | 1 | Sticky early-answer flag |
| mute_flag | output | 1 | Sticky no-answer / answer-during-reset flag |
| answered | output | 1 | Card answered, counter stopped |

## Verification
The bench builds the monitor with an 8-bit counter, IGNORE_TICKS=4, COLD_TICKS=12, EARLY_TICKS=3 and MUTE_TICKS=10. These values shrink every window to a few ticks, so the bench can sweep the start-bit position over every count of the cold phase and every count of the warm phase, including each window edge and the no-answer case. Because every trial is short, the bench can also probe the idle states after each outcome and check that the flags stay set across an enable drop.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_COLD   = 3'd1,
        ST_WARM   = 3'd2,
        ST_DONE   = 3'd3,
        ST_SILENT = 3'd4,
        ST_HALT   = 3'd5
    } atr_state_e;
endpackage

// File: rtl/atr_edge_det.sv
module atr_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic fall_seen
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // The line idles high, so every stage resets high and no edge appears at start.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b1;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall_seen = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/atr_tick_counter.sv
module atr_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count <= '0;
        else if (clr)                      count <= '0;
        else if (inc && count != CNT_MAX)  count <= count + 1'b1;
    end
endmodule

// File: rtl/atr_seq_fsm.sv
module atr_seq_fsm
    import atr_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int IGNORE_TICKS = 200,
    parameter int COLD_TICKS   = 42100,
    parameter int EARLY_TICKS  = 370,
    parameter int MUTE_TICKS   = 42100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             start_bit,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             card_rst,
    output logic             early_flag,
    output logic             mute_flag,
    output logic             answered
);
    localparam logic [CNT_W-1:0] IGN_C   = CNT_W'(IGNORE_TICKS);
    localparam logic [CNT_W-1:0] COLD_C  = CNT_W'(COLD_TICKS - 1);
    localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(EARLY_TICKS);
    localparam logic [CNT_W-1:0] MUTE_C  = CNT_W'(MUTE_TICKS - 1);

    atr_state_e state_q, state_d;
    logic       set_early, set_mute;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state and counter control
    always_comb begin
        state_d   = state_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        set_early = 1'b0;
        set_mute  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_clr = 1'b1;
                if (enable) state_d = ST_COLD;
            end
            ST_COLD: begin
                if (!enable) begin
                    state_d = ST_OFF;
                    cnt_clr = 1'b1;
                end else if (start_bit && count >= IGN_C) begin
                    set_early = 1'b1;
                    set_mute  = 1'b1;
                    state_d   = ST_HALT;
                end else if (tick && count == COLD_C) begin
                    cnt_clr = 1'b1;
                    state_d = ST_WARM;
                end else begin
                    cnt_inc = tick;
                end
            end
            ST_WARM: begin
                if (!enable) begin
                    state_d = ST_OFF;
                    cnt_clr = 1'b1;
                end else if (start_bit) begin
                    set_early = (count < EARLY_C);
                    state_d   = ST_DONE;
                end else if (tick && count == MUTE_C) begin
                    set_mute = 1'b1;
                    state_d  = ST_SILENT;
                end else begin
                    cnt_inc = tick;
                end
            end
            ST_DONE, ST_SILENT, ST_HALT: begin
                if (!enable) begin
                    state_d = ST_OFF;
                    cnt_clr = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Sticky status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_flag <= 1'b0;
            mute_flag  <= 1'b0;
        end else begin
            if (set_early)     early_flag <= 1'b1;
            else if (flag_clr) early_flag <= 1'b0;
            if (set_mute)      mute_flag  <= 1'b1;
            else if (flag_clr) mute_flag  <= 1'b0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        card_rst = 1'b0;
        answered = 1'b0;
        unique case (state_q)
            ST_WARM, ST_SILENT: card_rst = 1'b1;
            ST_DONE: begin
                card_rst = 1'b1;
                answered = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/atr_window_monitor.sv
module atr_window_monitor #(
    parameter int CNT_W        = 16,
    parameter int IGNORE_TICKS = 200,
    parameter int COLD_TICKS   = 42100,
    parameter int EARLY_TICKS  = 370,
    parameter int MUTE_TICKS   = 42100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic io_in,
    input  logic flag_clr,
    output logic card_rst,
    output logic early_flag,
    output logic mute_flag,
    output logic answered
);
    logic             start_bit;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] tick_cnt;

    atr_edge_det #(.SYNC_STAGES(2)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (io_in),
        .fall_seen (start_bit)
    );

    atr_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (tick_cnt)
    );

    atr_seq_fsm #(
        .CNT_W        (CNT_W),
        .IGNORE_TICKS (IGNORE_TICKS),
        .COLD_TICKS   (COLD_TICKS),
        .EARLY_TICKS  (EARLY_TICKS),
        .MUTE_TICKS   (MUTE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .start_bit  (start_bit),
        .flag_clr   (flag_clr),
        .count      (tick_cnt),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .card_rst   (card_rst),
        .early_flag (early_flag),
        .mute_flag  (mute_flag),
        .answered   (answered)
    );
endmodule

// File: rtl/atr_window_checker.sv
module atr_window_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             flag_clr,
    input logic             card_rst,
    input logic             early_flag,
    input logic             mute_flag,
    input logic             answered,
    input logic [CNT_W-1:0] tick_cnt
);
    assert_disabled_rst_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!card_rst && !answered));

    assert_disabled_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (tick_cnt == '0));

    assert_answered_rst_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        answered |-> card_rst);

    assert_counter_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (answered && enable) |=> $stable(tick_cnt));

    assert_early_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (early_flag && !flag_clr) |=> early_flag);

    assert_mute_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_flag && !flag_clr) |=> mute_flag);

    assert_cold_mute_pairs_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mute_flag) && !card_rst) |-> $rose(early_flag));

    assert_rst_rise_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |-> $past(enable));
endmodule

bind atr_window_monitor atr_window_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .flag_clr   (flag_clr),
    .card_rst   (card_rst),
    .early_flag (early_flag),
    .mute_flag  (mute_flag),
    .answered   (answered),
    .tick_cnt   (tick_cnt)
);

// File: tb/test_atr_window_monitor.sv
`timescale 1ns/1ps
module test_atr_window_monitor;
    localparam int IGN  = 4;
    localparam int COLD = 12;
    localparam int ERL  = 3;
    localparam int MUTE = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, tick = 1'b0, io_in = 1'b1, flag_clr = 1'b0;
    logic card_rst, early_flag, mute_flag, answered;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    atr_window_monitor #(
        .CNT_W(8), .IGNORE_TICKS(IGN), .COLD_TICKS(COLD),
        .EARLY_TICKS(ERL), .MUTE_TICKS(MUTE)
    ) i_atr_window_monitor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .io_in(io_in),
        .flag_clr(flag_clr), .card_rst(card_rst), .early_flag(early_flag),
        .mute_flag(mute_flag), .answered(answered)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic io_drop();
        @(negedge clk) io_in = 1'b0;
        wait_cyc(4);
    endtask

    task automatic io_up();
        @(negedge clk) io_in = 1'b1;
        wait_cyc(4);
    endtask

    task automatic start_trial();
        @(negedge clk) enable = 1'b0;
        wait_cyc(2);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R8", "early after clear", early_flag, 1'b0);
        check("R8", "mute after clear", mute_flag, 1'b0);
        check("R9", "rst while disabled", card_rst, 1'b0);
        io_up();
        @(negedge clk) enable = 1'b1;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(3);
        check("R10", "rst after reset", card_rst, 1'b0);
        check("R10", "early after reset", early_flag, 1'b0);
        check("R10", "mute after reset", mute_flag, 1'b0);
        check("R10", "answered after reset", answered, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(2);

        // Cold phase: start bit after n ticks
        for (int n = 0; n < COLD; n++) begin
            start_trial();
            ticks(n);
            io_drop();
            if (n < IGN) begin
                check("R2", "early in guard", early_flag, 1'b0);
                check("R2", "mute in guard", mute_flag, 1'b0);
                check("R2", "rst in guard", card_rst, 1'b0);
                io_up();
                check("R1", "rising edge no flag", early_flag, 1'b0);
                ticks(COLD - n - 1);
                wait_cyc(1);
                check("R4", "rst one tick before release", card_rst, 1'b0);
                ticks(1);
                check("R4", "rst released on count", card_rst, 1'b1);
            end else begin
                check("R3", "early in cold", early_flag, 1'b1);
                check("R3", "mute in cold", mute_flag, 1'b1);
                check("R3", "rst held low", card_rst, 1'b0);
                check("R3", "answered low", answered, 1'b0);
                io_up();
                ticks(COLD);
                check("R3", "rst stays low idle", card_rst, 1'b0);
                @(negedge clk) enable = 1'b0;
                wait_cyc(2);
                check("R9", "early kept over disable", early_flag, 1'b1);
                check("R9", "mute kept over disable", mute_flag, 1'b1);
                check("R9", "rst low disabled", card_rst, 1'b0);
            end
        end

        // Warm phase: start bit after m ticks past reset release
        for (int m = 0; m <= MUTE; m++) begin
            start_trial();
            ticks(COLD);
            check("R4", "rst high", card_rst, 1'b1);
            ticks(m);
            if (m < MUTE) begin
                io_drop();
                check("R1", "falling edge detected", answered, 1'b1);
                if (m < ERL) begin
                    check("R5", "early in warm", early_flag, 1'b1);
                    check("R5", "no mute early", mute_flag, 1'b0);
                end else begin
                    check("R6", "no early in window", early_flag, 1'b0);
                    check("R6", "no mute in window", mute_flag, 1'b0);
                end
                io_up();
                ticks(MUTE);
                io_drop();
                check("R6", "answered holds", answered, 1'b1);
                check("R6", "no mute after answer", mute_flag, 1'b0);
                check("R6", "rst stays high", card_rst, 1'b1);
                @(negedge clk) enable = 1'b0;
                wait_cyc(2);
                check("R9", "answered drops", answered, 1'b0);
                check("R9", "rst drops", card_rst, 1'b0);
            end else begin
                wait_cyc(1);
                check("R7", "mute after silence", mute_flag, 1'b1);
                check("R7", "no early", early_flag, 1'b0);
                check("R7", "rst stays high", card_rst, 1'b1);
                check("R7", "answered low", answered, 1'b0);
                io_drop();
                check("R7", "late start bit ignored", answered, 1'b0);
                io_up();
            end
        end

        // Warm phase: one tick short of silence is still a wait
        start_trial();
        ticks(COLD + MUTE - 1);
        wait_cyc(1);
        check("R7", "no mute one tick short", mute_flag, 1'b0);
        ticks(1);
        check("R7", "mute on last tick", mute_flag, 1'b1);

        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R8", "clear pulse clears mute", mute_flag, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule